// File: doc/BRIEF.md
# Prescaled 16-bit Event Timer

This block is a 16-bit up-counting timer with a small register set reached over a synchronous single-cycle write port and a combinational read port. A mode word picks the count source: the system clock, the system clock divided by sixteen, or rising edges on an external pin. The mode word also holds an 8-bit prescaler that stretches the source, and it chooses between a counter that restarts after reaching a reference value and one that runs freely. When the counter meets the reference it raises a reference event. That event can request an interrupt and drives a timer output, either as a one-cycle pulse or as a toggle.

A second input pin can latch the running count into a capture register on a chosen edge. Software clears the event flags by writing ones to them. Both pins pass through a two-flop synchronizer.

A three-state controller follows the mode word:
- `ST_OFF`: the enable bit is clear and all timer state is held cleared.
- `ST_IDLE`: the timer is enabled but no source is selected, so the count holds.
- `ST_RUN`: the timer is enabled and a source is selected.

The transitions, each taken on a mode write, are:
- enable-with-source: `ST_OFF` or `ST_IDLE` to `ST_RUN`.
- enable-without-source: `ST_OFF` or `ST_RUN` to `ST_IDLE`.
- disable: any state to `ST_OFF`.

Top module: `gp_timer`

## Requirements
- R1: Writing the mode word (address 0) with bit 0 clear resets the counter, the capture register, both event flags and the timer output to zero. While bit 0 stays clear, the counter does not advance whatever the source field holds. After reset the mode word is 0 and the reference register (address 1) is 0xFFFF.
- R2: Mode bits 2:1 pick the count source: 00 holds the count, 01 selects the system clock, 10 selects the system clock divided by 16, and 11 selects synchronized rising edges of `tmr_pin`. The first divided tick comes 16 clocks after the mode write.
- R3: Mode bits 15:8 hold a prescale value P. The counter advances once per P+1 source ticks. Every mode write restarts both the prescaler and the divide-by-16 phase.
- R4: When mode bit 3 is set, a count tick that finds the counter equal to the reference loads zero, so a reference of N-1 gives a period of N ticks.
- R5: When mode bit 3 is clear, the counter runs freely and wraps from 0xFFFF to 0. A tick that finds the counter equal to the reference still raises the reference event.
- R6: The event word (address 4) shows the reference flag in bit 1 and the capture flag in bit 0. Writing 1 to a bit clears that flag; writing 0 leaves it unchanged.
- R7: When a flag is set by hardware in the same cycle that software writes 1 to clear it, the flag stays set.
- R8: Mode bits 7:6 select the capture edge of `cap_pin`: 00 off, 01 rising, 10 falling, 11 both. A selected edge copies the count into the capture register (address 2, read-only) and sets the capture flag.
- R9: `irq` is a level that is high when mode bit 4 is set and the reference flag is set, or when the capture edge field is non-zero and the capture flag is set.
- R10: Mode bit 5 clear makes `tout` a one-cycle pulse on each reference event. Mode bit 5 set makes `tout` toggle on each reference event.
- R11: Any write to the counter address (3) zeroes the counter, and that wins over a tick in the same cycle. A write to the capture address has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 3 | Register address (0 mode, 1 reference, 2 capture, 3 counter, 4 event) |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr`, combinational |
| tmr_pin | input | 1 | External count source, asynchronous |
| cap_pin | input | 1 | Capture trigger, asynchronous |
| irq | output | 1 | Level interrupt request |
| tout | output | 1 | Reference-event output, pulse or toggle |

## Verification
A vector table runs the counter under each source and several prescale values. The table crosses restart with free-running counting and toggle with pulse output. The final counts separate period N from N+1 and the divided source from the direct one. Boundary vectors stop exactly one tick before and exactly one tick on the reference, use a reference of zero, and cross the 0xFFFF wrap. A pin-driven run counts synchronized edges. Capture is tried with the edge selector set to off, rising and falling, so a latched value shows which edge fired. Clearing a flag while a reference hit lands in the same cycle shows whether the set wins.

// File: rtl/gpt_pkg.sv
package gpt_pkg;

    localparam int DATA_W = 16;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        A_MODE = 3'd0,
        A_REF  = 3'd1,
        A_CAP  = 3'd2,
        A_CNT  = 3'd3,
        A_EVT  = 3'd4
    } reg_addr_e;

    typedef enum logic [1:0] {
        ST_OFF,
        ST_IDLE,
        ST_RUN
    } run_state_e;

    typedef enum logic [1:0] {
        SRC_NONE  = 2'd0,
        SRC_SYS   = 2'd1,
        SRC_DIV16 = 2'd2,
        SRC_PIN   = 2'd3
    } clk_src_e;

    typedef enum logic [1:0] {
        CAP_OFF  = 2'd0,
        CAP_RISE = 2'd1,
        CAP_FALL = 2'd2,
        CAP_BOTH = 2'd3
    } cap_edge_e;

    // Field order reproduces the bit positions of the mode word.
    typedef struct packed {
        logic [7:0] psc;       // 15:8
        cap_edge_e  cap_edge;  // 7:6
        logic       tog;       // 5
        logic       irq_en;    // 4
        logic       restart;   // 3
        clk_src_e   src;       // 2:1
        logic       en;        // 0
    } mode_t;

endpackage

// File: rtl/gpt_sync.sv
module gpt_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q,
    output logic q_prev
);
    logic [STAGES-1:0] chain;

    genvar i;
    generate
        for (i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[0] <= 1'b0;
                    else        chain[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[i] <= 1'b0;
                    else        chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_prev <= 1'b0;
        else        q_prev <= chain[STAGES-1];
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/gpt_tick_gen.sv
module gpt_tick_gen
    import gpt_pkg::*;
#(
    parameter int PSC_W = 8,
    parameter int DIV   = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             phase_rst,
    input  clk_src_e         src,
    input  logic             pin_rise,
    input  logic [PSC_W-1:0] psc,
    output logic             tick
);
    localparam int DIV_W = $clog2(DIV);
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(DIV - 1);

    logic [DIV_W-1:0] div_q;
    logic [PSC_W-1:0] psc_q;
    logic             src_tick;

    always_comb begin
        unique case (src)
            SRC_SYS:   src_tick = run;
            SRC_DIV16: src_tick = run && (div_q == DIV_LAST);
            SRC_PIN:   src_tick = run && pin_rise;
            default:   src_tick = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (phase_rst || !run || src != SRC_DIV16) begin
            div_q <= '0;
        end else begin
            div_q <= (div_q == DIV_LAST) ? '0 : div_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            psc_q <= '0;
        end else if (phase_rst || !run) begin
            psc_q <= '0;
        end else if (src_tick) begin
            psc_q <= (psc_q == psc) ? '0 : psc_q + 1'b1;
        end
    end

    assign tick = src_tick && (psc_q == psc);

endmodule

// File: rtl/gpt_core.sv
module gpt_core
    import gpt_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         tick,
    input  logic         restart,
    input  logic         tog,
    input  logic [W-1:0] ref_val,
    input  logic         cnt_zero,
    input  cap_edge_e    cap_sel,
    input  logic         cap_lvl,
    input  logic         cap_lvl_prev,
    input  logic [1:0]   evt_w1c,
    output logic [W-1:0] cnt,
    output logic [W-1:0] cap,
    output logic         ref_flag,
    output logic         cap_flag,
    output logic         tout
);
    logic hit;
    logic cap_rise;
    logic cap_fall;
    logic cap_hit;

    assign hit      = tick && (cnt == ref_val);
    assign cap_rise = cap_lvl && !cap_lvl_prev;
    assign cap_fall = !cap_lvl && cap_lvl_prev;

    always_comb begin
        unique case (cap_sel)
            CAP_RISE: cap_hit = cap_rise;
            CAP_FALL: cap_hit = cap_fall;
            CAP_BOTH: cap_hit = cap_rise || cap_fall;
            default:  cap_hit = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr || cnt_zero) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= (restart && hit) ? '0 : cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap <= '0;
        end else if (clr) begin
            cap <= '0;
        end else if (cap_hit) begin
            cap <= cnt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ref_flag <= 1'b0;
            cap_flag <= 1'b0;
        end else if (clr) begin
            ref_flag <= 1'b0;
            cap_flag <= 1'b0;
        end else begin
            if (hit)             ref_flag <= 1'b1;
            else if (evt_w1c[1]) ref_flag <= 1'b0;
            if (cap_hit)         cap_flag <= 1'b1;
            else if (evt_w1c[0]) cap_flag <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   tout <= 1'b0;
        else if (clr) tout <= 1'b0;
        else if (tog) tout <= tout ^ hit;
        else          tout <= hit;
    end

endmodule

// File: rtl/gp_timer.sv
module gp_timer
    import gpt_pkg::*;
#(
    parameter int W       = 16,
    parameter int AW      = 3,
    parameter int SYNC_FF = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [AW-1:0] reg_addr,
    input  logic [W-1:0]  reg_wdata,
    output logic [W-1:0]  reg_rdata,
    input  logic          tmr_pin,
    input  logic          cap_pin,
    output logic          irq,
    output logic          tout
);
    localparam logic [W-1:0] REF_RST = '1;

    mode_t      mode_q;
    mode_t      wr_mode;
    logic [W-1:0] ref_q;
    run_state_e state_q;
    run_state_e state_d;

    logic mode_wr;
    logic run;
    logic clr;
    logic cnt_zero;
    logic [1:0] evt_w1c;
    logic tick;
    logic pin_lvl, pin_prev;
    logic cap_lvl, cap_prev;
    logic [W-1:0] cnt;
    logic [W-1:0] cap;
    logic ref_flag;
    logic cap_flag;

    assign wr_mode  = mode_t'(reg_wdata[15:0]);
    assign mode_wr  = reg_wr && (reg_addr == A_MODE);
    assign cnt_zero = reg_wr && (reg_addr == A_CNT);
    assign evt_w1c  = (reg_wr && reg_addr == A_EVT) ? reg_wdata[1:0] : 2'b00;

    // Register file.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= '0;
            ref_q  <= REF_RST;
        end else if (reg_wr) begin
            if (reg_addr == A_MODE) mode_q <= wr_mode;
            if (reg_addr == A_REF)  ref_q  <= reg_wdata;
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    // Next state from the written mode word.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: begin
                if (mode_wr && wr_mode.en)
                    state_d = (wr_mode.src == SRC_NONE) ? ST_IDLE : ST_RUN;
            end
            ST_IDLE: begin
                if (mode_wr) begin
                    if (!wr_mode.en)                 state_d = ST_OFF;
                    else if (wr_mode.src != SRC_NONE) state_d = ST_RUN;
                end
            end
            ST_RUN: begin
                if (mode_wr) begin
                    if (!wr_mode.en)                 state_d = ST_OFF;
                    else if (wr_mode.src == SRC_NONE) state_d = ST_IDLE;
                end
            end
            default: state_d = ST_OFF;
        endcase
    end

    // Controls derived from the state.
    always_comb begin
        run = 1'b0;
        clr = 1'b0;
        unique case (state_q)
            ST_OFF:  clr = 1'b1;
            ST_IDLE: clr = mode_wr && !wr_mode.en;
            ST_RUN: begin
                run = 1'b1;
                clr = mode_wr && !wr_mode.en;
            end
            default: clr = 1'b1;
        endcase
    end

    gpt_sync #(.STAGES(SYNC_FF)) u_pin_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .d      (tmr_pin),
        .q      (pin_lvl),
        .q_prev (pin_prev)
    );

    gpt_sync #(.STAGES(SYNC_FF)) u_cap_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .d      (cap_pin),
        .q      (cap_lvl),
        .q_prev (cap_prev)
    );

    gpt_tick_gen #(.PSC_W(8), .DIV(16)) u_tick (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .phase_rst (mode_wr),
        .src       (mode_q.src),
        .pin_rise  (pin_lvl && !pin_prev),
        .psc       (mode_q.psc),
        .tick      (tick)
    );

    gpt_core #(.W(W)) u_core (
        .clk          (clk),
        .rst_n        (rst_n),
        .clr          (clr),
        .tick         (tick),
        .restart      (mode_q.restart),
        .tog          (mode_q.tog),
        .ref_val      (ref_q),
        .cnt_zero     (cnt_zero),
        .cap_sel      (mode_q.cap_edge),
        .cap_lvl      (cap_lvl),
        .cap_lvl_prev (cap_prev),
        .evt_w1c      (evt_w1c),
        .cnt          (cnt),
        .cap          (cap),
        .ref_flag     (ref_flag),
        .cap_flag     (cap_flag),
        .tout         (tout)
    );

    assign irq = (mode_q.irq_en && ref_flag) ||
                 ((mode_q.cap_edge != CAP_OFF) && cap_flag);

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            A_MODE:  reg_rdata = mode_q;
            A_REF:   reg_rdata = ref_q;
            A_CAP:   reg_rdata = cap;
            A_CNT:   reg_rdata = cnt;
            A_EVT:   reg_rdata = {{(W-2){1'b0}}, ref_flag, cap_flag};
            default: reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/gp_timer_chk.sv
module gp_timer_chk
    import gpt_pkg::*;
#(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input run_state_e   state,
    input mode_t        mode,
    input logic [W-1:0] cnt,
    input logic [W-1:0] ref_val,
    input logic         tick,
    input logic         clr,
    input logic         cnt_zero,
    input logic         ref_flag,
    input logic         cap_flag,
    input logic         irq
);
    // R1
    disabled_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mode.en |-> (cnt == '0 && !ref_flag && !cap_flag));

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !cnt_zero && !clr) |=> $stable(cnt));

    // R4
    restart_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && tick && mode.restart && cnt == ref_val && !clr)
        |=> cnt == '0);

    // R7
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && tick && cnt == ref_val && !clr) |=> ref_flag);

    // R8
    cap_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cap_flag) |-> ($past(mode.cap_edge) != CAP_OFF));

    // R9
    irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (ref_flag || cap_flag));

endmodule

bind gp_timer gp_timer_chk #(.W(W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .state    (state_q),
    .mode     (mode_q),
    .cnt      (cnt),
    .ref_val  (ref_q),
    .tick     (tick),
    .clr      (clr),
    .cnt_zero (cnt_zero),
    .ref_flag (ref_flag),
    .cap_flag (cap_flag),
    .irq      (irq)
);

// File: tb/gp_timer_test.sv
module gp_timer_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [15:0] reg_wdata = 16'd0;
    logic [15:0] reg_rdata;
    logic        tmr_pin = 1'b0;
    logic        cap_pin = 1'b0;
    logic        irq;
    logic        tout;

    int n_tests = 0;
    int n_fail  = 0;

    always #4 clk = ~clk;

    gp_timer uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .tmr_pin   (tmr_pin),
        .cap_pin   (cap_pin),
        .irq       (irq),
        .tout      (tout)
    );

    localparam logic [2:0] AD_MODE = 3'd0;
    localparam logic [2:0] AD_REF  = 3'd1;
    localparam logic [2:0] AD_CAP  = 3'd2;
    localparam logic [2:0] AD_CNT  = 3'd3;
    localparam logic [2:0] AD_EVT  = 3'd4;

    typedef struct packed {
        logic [15:0] mode;
        logic [15:0] refv;
        logic [31:0] ticks;
        logic [15:0] cnt;
        logic        flag;
        logic        tout;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VEC [NV] = '{
        '{16'h0003, 16'd100,    32'd20,    16'd20, 1'b0, 1'b0},
        '{16'h002B, 16'd4,      32'd23,    16'd3,  1'b1, 1'b0},
        '{16'h0303, 16'd1000,   32'd40,    16'd10, 1'b0, 1'b0},
        '{16'h012B, 16'd2,      32'd20,    16'd1,  1'b1, 1'b1},
        '{16'h0005, 16'hFFFF,   32'd100,   16'd6,  1'b0, 1'b0},
        '{16'h010D, 16'd1,      32'd130,   16'd0,  1'b1, 1'b0},
        '{16'h0003, 16'd5,      32'd6,     16'd6,  1'b1, 1'b0},
        '{16'h0003, 16'd5,      32'd5,     16'd5,  1'b0, 1'b0},
        '{16'h000B, 16'd0,      32'd7,     16'd0,  1'b1, 1'b0},
        '{16'h0003, 16'hFFFF,   32'd65538, 16'd2,  1'b1, 1'b0}
    };

    task automatic check(input string tag, input logic [15:0] got,
                         input logic [15:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_wr    = 1'b1;
        reg_addr  = a;
        reg_wdata = d;
        @(posedge clk);
        #1;
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic finish_up;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired got 1 expected 0");
        finish_up();
    end

    initial begin
        logic [15:0] v;
        int highs;

        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 R11: state after reset
        rd(AD_MODE, v); check("R1 mode after reset", v, 16'h0000);
        rd(AD_REF, v);  check("R1 ref after reset", v, 16'hFFFF);
        rd(AD_CNT, v);  check("R1 count after reset", v, 16'h0000);
        rd(AD_EVT, v);  check("R1 events after reset", v, 16'h0000);
        check("R9 irq after reset", {15'd0, irq}, 16'd0);
        check("R10 tout after reset", {15'd0, tout}, 16'd0);

        // R2 R3 R4 R5 R10: vector table
        for (int i = 0; i < NV; i++) begin
            wr(AD_MODE, 16'h0000);
            wr(AD_REF, VEC[i].refv);
            wr(AD_MODE, VEC[i].mode);
            repeat (int'(VEC[i].ticks) - 1) @(posedge clk);
            wr(AD_MODE, VEC[i].mode & 16'hFFF9);
            repeat (2) @(posedge clk);
            rd(AD_CNT, v);
            check($sformatf("R2/R3/R4/R5 vector %0d count", i), v, VEC[i].cnt);
            rd(AD_EVT, v);
            check($sformatf("R4/R5/R6 vector %0d ref flag", i), {15'd0, v[1]},
                  {15'd0, VEC[i].flag});
            check($sformatf("R10 vector %0d tout", i), {15'd0, tout},
                  {15'd0, VEC[i].tout});
        end

        // R1: disable clears state and blocks counting
        wr(AD_MODE, 16'h0000);
        wr(AD_REF, 16'd3);
        wr(AD_MODE, 16'h0003);
        repeat (10) @(posedge clk);
        wr(AD_MODE, 16'h0002);
        repeat (10) @(posedge clk);
        rd(AD_CNT, v); check("R1 count held at zero while disabled", v, 16'd0);
        rd(AD_EVT, v); check("R1 flags cleared by disable", v, 16'd0);

        // R2: external pin as source
        wr(AD_MODE, 16'h0000);
        wr(AD_REF, 16'hFFFF);
        wr(AD_MODE, 16'h0007);
        for (int p = 0; p < 5; p++) begin
            @(negedge clk); tmr_pin = 1'b1;
            repeat (3) @(negedge clk);
            tmr_pin = 1'b0;
            repeat (3) @(negedge clk);
        end
        repeat (8) @(posedge clk);
        wr(AD_MODE, 16'h0001);
        rd(AD_CNT, v); check("R2 pin edges counted", v, 16'd5);

        // R11: counter write zeroes and wins over a tick
        wr(AD_MODE, 16'h0003);
        repeat (10) @(posedge clk);
        wr(AD_CNT, 16'h1234);
        wr(AD_MODE, 16'h0001);
        rd(AD_CNT, v); check("R11 count after zeroing write", v, 16'd1);

        // R8 R9 R6: capture on rising edge
        wr(AD_MODE, 16'h0000);
        wr(AD_MODE, 16'h0003);
        repeat (19) @(posedge clk);
        wr(AD_MODE, 16'h0041);
        @(negedge clk); cap_pin = 1'b1;
        repeat (5) @(posedge clk);
        rd(AD_CAP, v); check("R8 rising capture value", v, 16'd20);
        rd(AD_EVT, v); check("R8 capture flag set", v, 16'h0001);
        check("R9 irq from capture", {15'd0, irq}, 16'd1);
        wr(AD_CAP, 16'hBEEF);
        rd(AD_CAP, v); check("R11 capture register not writable", v, 16'd20);
        wr(AD_EVT, 16'h0002);
        rd(AD_EVT, v); check("R6 zero bit leaves capture flag", v, 16'h0001);
        wr(AD_EVT, 16'h0001);
        rd(AD_EVT, v); check("R6 one bit clears capture flag", v, 16'h0000);
        check("R9 irq drops after clear", {15'd0, irq}, 16'd0);
        @(negedge clk); cap_pin = 1'b0;
        repeat (5) @(posedge clk);
        rd(AD_EVT, v); check("R8 falling edge ignored in rising mode", v, 16'h0000);

        // R8: falling edge mode
        wr(AD_CNT, 16'h0000);
        wr(AD_MODE, 16'h0081);
        @(negedge clk); cap_pin = 1'b1;
        repeat (5) @(posedge clk);
        rd(AD_EVT, v); check("R8 rising edge ignored in falling mode", v, 16'h0000);
        @(negedge clk); cap_pin = 1'b0;
        repeat (5) @(posedge clk);
        rd(AD_EVT, v); check("R8 falling capture flag", v, 16'h0001);
        rd(AD_CAP, v); check("R8 falling capture value", v, 16'd0);

        // R8: capture disabled
        wr(AD_EVT, 16'h0003);
        wr(AD_MODE, 16'h0001);
        @(negedge clk); cap_pin = 1'b1;
        repeat (5) @(posedge clk);
        @(negedge clk); cap_pin = 1'b0;
        repeat (5) @(posedge clk);
        rd(AD_EVT, v); check("R8 no capture when off", v, 16'h0000);

        // R9: reference interrupt enabled and disabled
        wr(AD_MODE, 16'h0000);
        wr(AD_REF, 16'd2);
        wr(AD_MODE, 16'h001B);
        repeat (9) @(posedge clk);
        wr(AD_MODE, 16'h0019);
        @(negedge clk);
        check("R9 irq from reference event", {15'd0, irq}, 16'd1);
        wr(AD_EVT, 16'h0002);
        @(negedge clk);
        check("R9 irq low after flag clear", {15'd0, irq}, 16'd0);
        wr(AD_MODE, 16'h0000);
        wr(AD_MODE, 16'h000B);
        repeat (9) @(posedge clk);
        wr(AD_MODE, 16'h0009);
        rd(AD_EVT, v); check("R9 flag set with irq disabled", v, 16'h0002);
        check("R9 irq masked", {15'd0, irq}, 16'd0);

        // R7: clear collides with a reference hit
        wr(AD_MODE, 16'h0000);
        wr(AD_REF, 16'd0);
        wr(AD_MODE, 16'h000B);
        repeat (3) @(posedge clk);
        wr(AD_EVT, 16'h0002);
        rd(AD_EVT, v); check("R7 set wins over clear", v, 16'h0002);

        // R10: pulse output, one high cycle per period
        wr(AD_MODE, 16'h0000);
        wr(AD_REF, 16'd3);
        wr(AD_MODE, 16'h000B);
        highs = 0;
        for (int c = 0; c < 40; c++) begin
            @(posedge clk);
            #1;
            if (tout) highs++;
        end
        check("R10 pulse count over 40 ticks", 16'(highs), 16'd10);
        wr(AD_MODE, 16'h0000);

        finish_up();
    end

endmodule